// File: doc/BRIEF.md
# Privileged Instruction Trap Decoder

This block decides whether a small group of privileged instructions may run. The covered instructions are wait-for-interrupt, wait-on-reservation-set with no timeout, the address-translation fence, the two hypervisor fences (virtual-machine and guest-physical), and the hypervisor virtual-machine loads and stores, including the execute-permission loads. The block does not carry out the instruction. It gives back one verdict: either the instruction is allowed, or it traps. A trap is either an illegal-instruction trap or a virtual-instruction trap.

The decoder takes a request strobe. With it come the instruction class, the current privilege level, the virtualization flag and whether supervisor mode exists. It also takes the trap-control bits: timeout-wait, trap-VM, virtual timeout-wait, virtual trap-VM, hypervisor-user-access, the hypervisor's supervisor-previous-privilege bit, and the guest-level user-memory-access bit.

The verdict is registered. It appears one cycle after the request, together with a done strobe. For hypervisor loads and stores the block also returns the translation mode that the access must use.

Top module: `priv_trap_decoder`

## Requirements
- R1: A request with `req_valid` high gives `done_valid` high on the following cycle. Without a request, `done_valid` is low on the following cycle and the verdict outputs hold their previous values.
- R2: Wait-for-interrupt (class 0) traps as illegal in three cases: the timeout-wait bit is set in supervisor mode; the timeout-wait bit is set in user mode on a core without supervisor mode; user mode runs without virtualization on a core with supervisor mode.
- R3: When R2 does not apply, wait-for-interrupt traps as a virtual instruction under virtualization in user mode, or in supervisor mode with virtual timeout-wait set. Otherwise it is allowed.
- R4: Wait-on-reservation-set (class 1) traps as a virtual instruction when all of these hold: virtualized, in user or supervisor mode, virtual timeout-wait set, timeout-wait clear. Otherwise it traps as illegal when below machine mode with timeout-wait set. Otherwise it is allowed.
- R5: The address-translation fence (class 2) behaves as follows. Without virtualization it is illegal in user mode, and illegal in supervisor mode with trap-VM set. With virtualization it traps as a virtual instruction in user mode or when virtual trap-VM is set. Otherwise it is allowed.
- R6: The hypervisor virtual-machine fence (class 3) traps as a virtual instruction whenever virtualized. Otherwise it is allowed in machine mode or supervisor mode, and is illegal in user mode.
- R7: The guest-physical fence (class 4) follows R6, with one check ahead of the R6 rules: non-virtualized supervisor mode with trap-VM set is illegal.
- R8: Hypervisor load/store (class 5) and execute-load (class 6) are always allowed in machine mode. Otherwise they trap as a virtual instruction when virtualized. Otherwise they are illegal in user mode with hypervisor-user-access clear. Otherwise they are allowed.
- R9: For classes 5 and 6, `xlate_mode` is {1, mode[1:0]}. Bit 2, the two-stage flag, is always 1. Mode is 0 for user and 1 for supervisor, taken from the supervisor-previous-privilege bit. It becomes 2 (supervisor with user-memory access) when the class is 5, the bit selects supervisor, and the guest user-memory-access bit is set. For all other classes the field is 0.
- R10: Class 7 is not a supported instruction and always traps as illegal.
- R11: After reset, `done_valid`, `allowed`, `trap_valid`, `trap_cause` and `xlate_mode` are all 0.
- R12: On every verdict, exactly one of `allowed` and `trap_valid` is high. `trap_cause` is 2 for illegal instruction, 22 for virtual instruction, and 0 when the instruction is allowed. Privilege is encoded as 0 for user, 1 for supervisor and 3 for machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_class | input | 3 | Instruction class code |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_on | input | 1 | Virtualization active |
| s_present | input | 1 | Core implements supervisor mode |
| trap_wait | input | 1 | Timeout-wait trap enable |
| trap_vm | input | 1 | Translation-management trap enable |
| vtrap_wait | input | 1 | Virtual timeout-wait trap enable |
| vtrap_vm | input | 1 | Virtual translation-management trap enable |
| hyp_user_ok | input | 1 | User mode may issue hypervisor loads/stores |
| hyp_spv_priv | input | 1 | Privilege used for hypervisor loads/stores (1 = supervisor) |
| vs_sum | input | 1 | Guest supervisor may access user pages |
| done_valid | output | 1 | Verdict valid strobe |
| allowed | output | 1 | Instruction may execute |
| trap_valid | output | 1 | Instruction traps |
| trap_cause | output | 5 | Trap cause code |
| xlate_mode | output | 3 | Translation mode for hypervisor loads/stores |

## Verification
A vector table runs each class through the privilege and virtualization combinations that sit on either side of each rule. Examples are supervisor versus user, supervisor present or absent, virtualized or not, and each trap bit set and clear. Each pair of vectors differs in one input and flips the verdict between allowed, illegal and virtual. This shows that the right bit gates the right outcome. Cases where two rules compete show that the ordering is right: a wait-on-reservation-set with both wait bits set, and the guest-physical fence with trap-VM set in machine mode. For the hypervisor load/store classes, the bench tries the mode inputs in each combination. This separates the user-memory-access selection of plain loads from that of execute loads. Further directed steps check the reset state and that the outputs hold when there is no request.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

    localparam int CLASS_W = 3;
    localparam int PRIV_W  = 2;
    localparam int CAUSE_W = 5;
    localparam int MODE_W  = 3;

    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = CAUSE_W'(2);
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = CAUSE_W'(22);

    typedef enum logic [CLASS_W-1:0] {
        CLS_WFI      = 3'd0,
        CLS_WRS      = 3'd1,
        CLS_ATFENCE  = 3'd2,
        CLS_HFENCE_V = 3'd3,
        CLS_HFENCE_G = 3'd4,
        CLS_HLSV     = 3'd5,
        CLS_HLVX     = 3'd6,
        CLS_NONE     = 3'd7
    } instr_class_e;

    typedef enum logic [PRIV_W-1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        VD_ALLOW   = 2'd0,
        VD_ILLEGAL = 2'd1,
        VD_VIRT    = 2'd2
    } verdict_e;

    typedef struct packed {
        logic virt_on;
        logic s_present;
        logic trap_wait;
        logic trap_vm;
        logic vtrap_wait;
        logic vtrap_vm;
        logic hyp_user_ok;
        logic hyp_spv_priv;
        logic vs_sum;
    } ctl_bits_t;

    typedef struct packed {
        logic                allowed;
        logic                trap;
        logic [CAUSE_W-1:0]  cause;
    } result_t;

    function automatic result_t to_result(verdict_e v);
        result_t r;
        r.allowed = (v == VD_ALLOW);
        r.trap    = (v != VD_ALLOW);
        r.cause   = (v == VD_ILLEGAL) ? CAUSE_ILLEGAL :
                    (v == VD_VIRT)    ? CAUSE_VIRT    : '0;
        return r;
    endfunction

endpackage

// File: rtl/pt_rule_eval.sv
module pt_rule_eval
    import priv_trap_pkg::*;
(
    input  instr_class_e cls,
    input  priv_e        priv,
    input  ctl_bits_t    ctl,
    output verdict_e     verdict
);
    logic in_u, in_s, in_m, v;

    always_comb begin
        in_u = (priv == PRV_USER);
        in_s = (priv == PRV_SUPER);
        in_m = (priv == PRV_MACH);
        v    = ctl.virt_on;
        verdict = VD_ILLEGAL;
        unique case (cls)
            CLS_WFI: begin
                if (((in_s || (!ctl.s_present && in_u)) && ctl.trap_wait) ||
                    (ctl.s_present && in_u && !v))
                    verdict = VD_ILLEGAL;
                else if (v && (in_u || (in_s && ctl.vtrap_wait)))
                    verdict = VD_VIRT;
                else
                    verdict = VD_ALLOW;
            end
            CLS_WRS: begin
                if (v && (in_s || in_u) && ctl.vtrap_wait && !ctl.trap_wait)
                    verdict = VD_VIRT;
                else if (!in_m && ctl.trap_wait)
                    verdict = VD_ILLEGAL;
                else
                    verdict = VD_ALLOW;
            end
            CLS_ATFENCE: begin
                if (!v && (in_u || (in_s && ctl.trap_vm)))
                    verdict = VD_ILLEGAL;
                else if (v && (in_u || ctl.vtrap_vm))
                    verdict = VD_VIRT;
                else
                    verdict = VD_ALLOW;
            end
            CLS_HFENCE_V, CLS_HFENCE_G: begin
                if (cls == CLS_HFENCE_G && in_s && !v && ctl.trap_vm)
                    verdict = VD_ILLEGAL;
                else if (v)
                    verdict = VD_VIRT;
                else if (in_m || in_s)
                    verdict = VD_ALLOW;
                else
                    verdict = VD_ILLEGAL;
            end
            CLS_HLSV, CLS_HLVX: begin
                if (in_m)
                    verdict = VD_ALLOW;
                else if (v)
                    verdict = VD_VIRT;
                else if (in_u && !ctl.hyp_user_ok)
                    verdict = VD_ILLEGAL;
                else
                    verdict = VD_ALLOW;
            end
            default: verdict = VD_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/pt_xlate_sel.sv
module pt_xlate_sel
    import priv_trap_pkg::*;
(
    input  instr_class_e      cls,
    input  ctl_bits_t         ctl,
    output logic [MODE_W-1:0] mode
);
    logic hyp_access, exec_access;

    always_comb begin
        hyp_access  = (cls == CLS_HLSV) || (cls == CLS_HLVX);
        exec_access = (cls == CLS_HLVX);
        mode = '0;
        if (hyp_access) begin
            if (!exec_access && ctl.hyp_spv_priv && ctl.vs_sum)
                mode = 3'b110;
            else
                mode = {1'b1, 1'b0, ctl.hyp_spv_priv};
        end
    end
endmodule

// File: rtl/priv_trap_decoder.sv
module priv_trap_decoder
    import priv_trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [CLASS_W-1:0] req_class,
    input  logic [PRIV_W-1:0]  cur_priv,
    input  logic               virt_on,
    input  logic               s_present,
    input  logic               trap_wait,
    input  logic               trap_vm,
    input  logic               vtrap_wait,
    input  logic               vtrap_vm,
    input  logic               hyp_user_ok,
    input  logic               hyp_spv_priv,
    input  logic               vs_sum,
    output logic               done_valid,
    output logic               allowed,
    output logic               trap_valid,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [MODE_W-1:0]  xlate_mode
);
    ctl_bits_t         ctl;
    instr_class_e      cls;
    priv_e             priv;
    verdict_e          verdict;
    result_t           res;
    logic [MODE_W-1:0] mode_next;

    assign cls  = instr_class_e'(req_class);
    assign priv = priv_e'(cur_priv);
    assign ctl  = '{virt_on: virt_on, s_present: s_present, trap_wait: trap_wait,
                    trap_vm: trap_vm, vtrap_wait: vtrap_wait, vtrap_vm: vtrap_vm,
                    hyp_user_ok: hyp_user_ok, hyp_spv_priv: hyp_spv_priv,
                    vs_sum: vs_sum};

    pt_rule_eval u_rules (
        .cls     (cls),
        .priv    (priv),
        .ctl     (ctl),
        .verdict (verdict)
    );

    pt_xlate_sel u_xlate (
        .cls  (cls),
        .ctl  (ctl),
        .mode (mode_next)
    );

    assign res = to_result(verdict);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_valid <= 1'b0;
            allowed    <= 1'b0;
            trap_valid <= 1'b0;
            trap_cause <= '0;
            xlate_mode <= '0;
        end else begin
            done_valid <= req_valid;
            if (req_valid) begin
                allowed    <= res.allowed;
                trap_valid <= res.trap;
                trap_cause <= res.cause;
                xlate_mode <= mode_next;
            end
        end
    end
endmodule

// File: rtl/priv_trap_decoder_chk.sv
module priv_trap_decoder_chk
    import priv_trap_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [CLASS_W-1:0] req_class,
    input logic [PRIV_W-1:0]  cur_priv,
    input logic               virt_on,
    input logic               done_valid,
    input logic               allowed,
    input logic               trap_valid,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic [MODE_W-1:0]  xlate_mode
);
    a_r1_done_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> done_valid);
    a_r1_idle_no_done: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !done_valid);
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (allowed ^ trap_valid));
    a_r12_cause_code: assert property (@(posedge clk) disable iff (rst)
        (done_valid && trap_valid) |-> (trap_cause == CAUSE_ILLEGAL || trap_cause == CAUSE_VIRT));
    a_r8_machine_hyp_ok: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_priv == 2'd3 && (req_class == 3'd5 || req_class == 3'd6)) |=> allowed);
    a_r9_two_stage: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_class == 3'd5 || req_class == 3'd6)) |=> xlate_mode[2]);
    a_r10_unknown_illegal: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class == 3'd7) |=> (trap_valid && trap_cause == CAUSE_ILLEGAL));
    a_r6_vfence_virtual: assert property (@(posedge clk) disable iff (rst)
        (req_valid && virt_on && req_class == 3'd3) |=> (trap_valid && trap_cause == CAUSE_VIRT));
endmodule

bind priv_trap_decoder priv_trap_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_class  (req_class),
    .cur_priv   (cur_priv),
    .virt_on    (virt_on),
    .done_valid (done_valid),
    .allowed    (allowed),
    .trap_valid (trap_valid),
    .trap_cause (trap_cause),
    .xlate_mode (xlate_mode)
);

// File: tb/sim_priv_trap_decoder.sv
module sim_priv_trap_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_class = '0;
    logic [1:0] cur_priv = '0;
    logic       virt_on = 0, s_present = 0, trap_wait = 0, trap_vm = 0;
    logic       vtrap_wait = 0, vtrap_vm = 0, hyp_user_ok = 0, hyp_spv_priv = 0, vs_sum = 0;
    logic       done_valid, allowed, trap_valid;
    logic [4:0] trap_cause;
    logic [2:0] xlate_mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    priv_trap_decoder u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .cur_priv(cur_priv), .virt_on(virt_on), .s_present(s_present),
        .trap_wait(trap_wait), .trap_vm(trap_vm), .vtrap_wait(vtrap_wait),
        .vtrap_vm(vtrap_vm), .hyp_user_ok(hyp_user_ok), .hyp_spv_priv(hyp_spv_priv),
        .vs_sum(vs_sum), .done_valid(done_valid), .allowed(allowed),
        .trap_valid(trap_valid), .trap_cause(trap_cause), .xlate_mode(xlate_mode)
    );

    // Vector: {class[3], priv[2], virt, s_pres, tw, tvm, vtw, vtvm, hu, spvp, sum, exp[2], mode[3]}
    // exp: 0 allowed, 1 illegal (cause 2), 2 virtual (cause 22)
    localparam int NV = 32;
    localparam logic [18:0] VEC [NV] = '{
        {3'd0, 2'd1, 9'b0_1_1_0_0_0_0_0_0, 2'd1, 3'd0}, // R2 S with TW
        {3'd0, 2'd0, 9'b0_0_1_0_0_0_0_0_0, 2'd1, 3'd0}, // R2 U no S-mode with TW
        {3'd0, 2'd0, 9'b0_1_0_0_0_0_0_0_0, 2'd1, 3'd0}, // R2 U non-virt with S-mode
        {3'd0, 2'd0, 9'b1_1_0_0_0_0_0_0_0, 2'd2, 3'd0}, // R3 U virt
        {3'd0, 2'd1, 9'b1_1_0_0_1_0_0_0_0, 2'd2, 3'd0}, // R3 S virt VTW
        {3'd0, 2'd1, 9'b1_1_0_0_0_0_0_0_0, 2'd0, 3'd0}, // R3 S virt halt
        {3'd0, 2'd3, 9'b0_1_1_0_0_0_0_0_0, 2'd0, 3'd0}, // R3 M halts despite TW
        {3'd0, 2'd0, 9'b1_1_1_0_0_0_0_0_0, 2'd2, 3'd0}, // R3 U virt TW
        {3'd0, 2'd0, 9'b0_0_0_0_0_0_0_0_0, 2'd0, 3'd0}, // R3 U no S-mode no TW
        {3'd1, 2'd1, 9'b1_1_0_0_1_0_0_0_0, 2'd2, 3'd0}, // R4 virtual
        {3'd1, 2'd1, 9'b1_1_1_0_1_0_0_0_0, 2'd1, 3'd0}, // R4 TW wins as illegal
        {3'd1, 2'd3, 9'b0_1_1_0_0_0_0_0_0, 2'd0, 3'd0}, // R4 M allowed
        {3'd1, 2'd0, 9'b0_1_0_0_0_0_0_0_0, 2'd0, 3'd0}, // R4 U allowed
        {3'd2, 2'd0, 9'b0_1_0_0_0_0_0_0_0, 2'd1, 3'd0}, // R5 U illegal
        {3'd2, 2'd1, 9'b0_1_0_1_0_0_0_0_0, 2'd1, 3'd0}, // R5 S TVM illegal
        {3'd2, 2'd1, 9'b0_1_0_0_0_0_0_0_0, 2'd0, 3'd0}, // R5 S allowed
        {3'd2, 2'd1, 9'b1_1_0_0_0_1_0_0_0, 2'd2, 3'd0}, // R5 virt VTVM
        {3'd2, 2'd1, 9'b1_1_0_1_0_0_0_0_0, 2'd0, 3'd0}, // R5 virt TVM ignored
        {3'd2, 2'd0, 9'b1_1_0_0_0_0_0_0_0, 2'd2, 3'd0}, // R5 virt U
        {3'd3, 2'd1, 9'b1_1_0_0_0_0_0_0_0, 2'd2, 3'd0}, // R6 virt
        {3'd3, 2'd1, 9'b0_1_0_1_0_0_0_0_0, 2'd0, 3'd0}, // R6 S allowed TVM ignored
        {3'd3, 2'd0, 9'b0_1_0_0_0_0_0_0_0, 2'd1, 3'd0}, // R6 U illegal
        {3'd4, 2'd1, 9'b0_1_0_1_0_0_0_0_0, 2'd1, 3'd0}, // R7 S TVM illegal
        {3'd4, 2'd3, 9'b0_1_0_1_0_0_0_0_0, 2'd0, 3'd0}, // R7 M TVM allowed
        {3'd4, 2'd0, 9'b1_1_0_0_0_0_0_0_0, 2'd2, 3'd0}, // R7 virt U
        {3'd5, 2'd3, 9'b0_1_0_0_0_0_0_1_1, 2'd0, 3'd6}, // R8 R9 M sum-mode
        {3'd5, 2'd1, 9'b1_1_0_0_0_0_0_0_0, 2'd2, 3'd4}, // R8 R9 virt, user mode
        {3'd5, 2'd0, 9'b0_1_0_0_0_0_0_1_0, 2'd1, 3'd5}, // R8 R9 U no HU
        {3'd5, 2'd0, 9'b0_1_0_0_0_0_1_1_1, 2'd0, 3'd6}, // R8 R9 U with HU
        {3'd6, 2'd1, 9'b0_1_0_0_0_0_0_1_1, 2'd0, 3'd5}, // R8 R9 exec ignores SUM
        {3'd6, 2'd3, 9'b0_1_0_0_0_0_0_0_0, 2'd0, 3'd4}, // R8 R9 M exec
        {3'd7, 2'd3, 9'b0_1_0_0_0_0_0_0_0, 2'd1, 3'd0}  // R10 unsupported
    };

    function automatic string req_tag(logic [2:0] c);
        case (c)
            3'd0: return "R2/R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd7: return "R10";
            default: return "R8/R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11 done_valid", 32'(done_valid), 0);
        check("R11 allowed", 32'(allowed), 0);
        check("R11 trap_valid", 32'(trap_valid), 0);
        check("R11 trap_cause", 32'(trap_cause), 0);
        check("R11 xlate_mode", 32'(xlate_mode), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            logic [1:0]  ex;
            logic [4:0]  ec;
            v = VEC[i];
            req_class = v[18:16];
            cur_priv  = v[15:14];
            {virt_on, s_present, trap_wait, trap_vm, vtrap_wait, vtrap_vm,
             hyp_user_ok, hyp_spv_priv, vs_sum} = v[13:5];
            ex = v[4:3];
            ec = (ex == 2'd1) ? 5'd2 : (ex == 2'd2) ? 5'd22 : 5'd0;
            req_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R1 done vec%0d", i), 32'(done_valid), 1);
            check($sformatf("%s allowed vec%0d", req_tag(v[18:16]), i), 32'(allowed), 32'(ex == 2'd0));
            check($sformatf("R12 trap vec%0d", i), 32'(trap_valid), 32'(ex != 2'd0));
            check($sformatf("%s cause vec%0d", req_tag(v[18:16]), i), 32'(trap_cause), 32'(ec));
            check($sformatf("R9 mode vec%0d", i), 32'(xlate_mode), 32'(v[2:0]));
        end

        // R1: no request -> done drops, verdict holds (last vector: illegal, cause 2)
        req_valid = 1'b0;
        req_class = 3'd5;
        cur_priv  = 2'd3;
        @(posedge clk);
        @(negedge clk);
        check("R1 idle done", 32'(done_valid), 0);
        check("R1 idle hold trap", 32'(trap_valid), 1);
        check("R1 idle hold cause", 32'(trap_cause), 2);
        check("R1 idle hold mode", 32'(xlate_mode), 0);

        // R11: reset mid-run clears outputs
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11 rerst trap", 32'(trap_valid), 0);
        check("R11 rerst cause", 32'(trap_cause), 0);
        rst = 1'b0;
        finish_run();
    end
endmodule